// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM and takes the device from power-on to an operational state. After reset it holds the clock-enable pin high and sends NOP commands for a stable-clock interval. The interval is computed from the clock frequency and the startup time, both given as parameters. It then precharges every bank and issues a parameterized number of auto-refresh commands. Last, it writes the mode register with a word built from three configuration ports: burst length, burst type and CAS latency.

Each command is followed by a parameterized recovery gap, filled with NOPs. The ready flag rises once the mode-register recovery time has elapsed. If the configuration holds a reserved code, the sequencer never sends the mode-register write. It raises an error flag instead and parks in a fault state.

The FSM states are:
- ST_STARTUP: the stable-clock wait.
- ST_PRECHARGE: the all-bank precharge.
- ST_WAIT_RP: precharge recovery.
- ST_REFRESH: one auto-refresh.
- ST_WAIT_RFC: refresh recovery.
- ST_MRS: the mode-register write.
- ST_WAIT_MRD: mode-register recovery.
- ST_READY: done.
- ST_FAULT: illegal configuration.

The transitions are:
- ST_STARTUP to ST_PRECHARGE when the startup timer expires.
- ST_PRECHARGE to ST_WAIT_RP unconditionally.
- ST_WAIT_RP to ST_REFRESH on timer expiry.
- ST_REFRESH to ST_WAIT_RFC unconditionally.
- ST_WAIT_RFC on timer expiry, to one of three states:
  - ST_REFRESH if more refreshes are owed;
  - otherwise ST_MRS if the configuration is legal;
  - otherwise ST_FAULT.
- ST_MRS to ST_WAIT_MRD unconditionally.
- ST_WAIT_MRD to ST_READY on timer expiry.
- ST_READY and ST_FAULT are terminal until reset.

Top module: `sdram_init_seq`

## Requirements
- R1: sd_cke is 1 in every cycle, during reset and after it.
- R2: After reset release, only NOP commands appear for STARTUP_CYC = CLK_MHZ*STARTUP_US clock cycles. The precharge appears in the cycle after the last of these. Commands are encoded {cs_n,ras_n,cas_n,we_n}: NOP=0111, PRECHARGE=0010, REFRESH=0001, MODE SET=0000.
- R3: The first non-NOP command is PRECHARGE, with sd_addr bit 10 set and all other address bits and sd_ba zero.
- R4: Exactly NUM_REFRESH REFRESH commands follow, with a minimum of 2. The first comes TRP_CYC cycles after the precharge, and each later one comes TRFC_CYC cycles after the previous one.
- R5: For a legal configuration, MODE SET comes TRFC_CYC cycles after the last REFRESH. sd_addr[2:0] carries the burst length code, sd_addr[3] the burst type, and sd_addr[6:4] the CAS latency code.
- R6: During MODE SET, sd_addr[12:7] and sd_ba are all zero.
- R7: Legality rules:
  - The CAS latency codes 010 and 011 are legal.
  - The burst length codes 000, 001, 010 and 011 are legal.
  - Code 111 (full page) is legal only with burst type 0.
  - Every other code is reserved.
  - A reserved code suppresses MODE SET: NOP is sent in its place. cfg_error rises in the cycle MODE SET would have appeared and stays high, and init_done stays 0.
- R8: init_done rises exactly TMRD_CYC cycles after MODE SET and stays high until reset. init_done and cfg_error are never both high.
- R9: Every cycle between and after the listed commands carries NOP, with sd_addr and sd_ba zero.
- R10: While rst_n is low, the command is NOP, sd_addr and sd_ba are zero, and init_done and cfg_error are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_burst_type | input | 1 | Burst type, 0 sequential, 1 interleave |
| cfg_cas_lat | input | 3 | CAS latency code |
| sd_cke | output | 1 | Clock enable to the device |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address lines |
| sd_ba | output | BA_W | Bank address lines |
| init_done | output | 1 | Initialization complete |
| cfg_error | output | 1 | Reserved configuration detected |

## Verification
A wrong state or a timer off by one shows directly at the command pins. The affected command moves by a cycle, or a NOP replaces it, and this is visible from the first command onward. The bench therefore compares every cycle of the command, address and flag outputs against a schedule computed from the parameters.

A refresh counter off by one shows as a missing or extra REFRESH and a shifted MODE SET. A wrong legality decision shows as a MODE SET in place of cfg_error, or the reverse, in the cycle MODE SET is due.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [3:0] {
        ST_STARTUP,
        ST_PRECHARGE,
        ST_WAIT_RP,
        ST_REFRESH,
        ST_WAIT_RFC,
        ST_MRS,
        ST_WAIT_MRD,
        ST_READY,
        ST_FAULT
    } init_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_PRE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sd_cmd_t CMD_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sd_cmd_t CMD_MRS  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/init_timer.sv
module init_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/mode_word_builder.sv
module mode_word_builder #(
    parameter int ADDR_W = 13
) (
    input  logic [2:0]        burst_len,
    input  logic              burst_type,
    input  logic [2:0]        cas_lat,
    output logic [ADDR_W-1:0] word,
    output logic              legal
);

    logic cas_ok;
    logic len_ok;

    always_comb begin
        cas_ok = (cas_lat == 3'b010) || (cas_lat == 3'b011);
        unique case (burst_len)
            3'b000, 3'b001, 3'b010, 3'b011: len_ok = 1'b1;
            3'b111:                         len_ok = !burst_type;
            default:                        len_ok = 1'b0;
        endcase
        legal = cas_ok && len_ok;
    end

    generate
        if (ADDR_W > 7) begin : g_pad
            assign word = {{(ADDR_W-7){1'b0}}, cas_lat, burst_type, burst_len};
        end else begin : g_nopad
            assign word = {cas_lat, burst_type, burst_len};
        end
    endgenerate

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ     = 100,
    parameter int STARTUP_US  = 200,
    parameter int TRP_CYC     = 3,
    parameter int TRFC_CYC    = 9,
    parameter int TMRD_CYC    = 2,
    parameter int NUM_REFRESH = 2,
    parameter int ADDR_W      = 13,
    parameter int BA_W        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_type,
    input  logic [2:0]        cfg_cas_lat,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba,
    output logic              init_done,
    output logic              cfg_error
);

    localparam int STARTUP_CYC = (CLK_MHZ * STARTUP_US < 1) ? 1 : CLK_MHZ * STARTUP_US;
    localparam int RP_W   = (TRP_CYC  < 2) ? 2 : TRP_CYC;
    localparam int RFC_W  = (TRFC_CYC < 2) ? 2 : TRFC_CYC;
    localparam int MRD_W  = (TMRD_CYC < 2) ? 2 : TMRD_CYC;
    localparam int REF_N  = (NUM_REFRESH < 2) ? 2 : NUM_REFRESH;
    localparam int MAX_A  = (STARTUP_CYC > RP_W) ? STARTUP_CYC : RP_W;
    localparam int MAX_B  = (RFC_W > MRD_W) ? RFC_W : MRD_W;
    localparam int MAX_T  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TMR_W  = $clog2(MAX_T + 1);
    localparam int REF_W  = $clog2(REF_N + 1);
    localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

    init_state_e        state_q, state_d;
    logic [REF_W-1:0]   ref_q;
    logic               tmr_load;
    logic [TMR_W-1:0]   tmr_val;
    logic               tmr_done;
    logic [ADDR_W-1:0]  mode_word;
    logic               cfg_legal;
    sd_cmd_t            cmd_q;

    init_timer #(
        .W       (TMR_W),
        .RST_VAL (STARTUP_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    mode_word_builder #(
        .ADDR_W (ADDR_W)
    ) u_word (
        .burst_len  (cfg_burst_len),
        .burst_type (cfg_burst_type),
        .cas_lat    (cfg_cas_lat),
        .word       (mode_word),
        .legal      (cfg_legal)
    );

    // Timer reload in each command state: the following wait state lasts val+1 cycles.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_PRECHARGE: begin tmr_load = 1'b1; tmr_val = TMR_W'(RP_W - 2);  end
            ST_REFRESH:   begin tmr_load = 1'b1; tmr_val = TMR_W'(RFC_W - 2); end
            ST_MRS:       begin tmr_load = 1'b1; tmr_val = TMR_W'(MRD_W - 2); end
            default:      ;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STARTUP:   if (tmr_done) state_d = ST_PRECHARGE;
            ST_PRECHARGE: state_d = ST_WAIT_RP;
            ST_WAIT_RP:   if (tmr_done) state_d = ST_REFRESH;
            ST_REFRESH:   state_d = ST_WAIT_RFC;
            ST_WAIT_RFC: begin
                if (tmr_done) begin
                    if (ref_q < REF_W'(REF_N)) state_d = ST_REFRESH;
                    else if (cfg_legal)        state_d = ST_MRS;
                    else                       state_d = ST_FAULT;
                end
            end
            ST_MRS:       state_d = ST_WAIT_MRD;
            ST_WAIT_MRD:  if (tmr_done) state_d = ST_READY;
            ST_READY:     state_d = ST_READY;
            ST_FAULT:     state_d = ST_FAULT;
            default:      state_d = ST_FAULT;
        endcase
    end

    // State register and refresh tally
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STARTUP;
            ref_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_REFRESH) ref_q <= ref_q + 1'b1;
        end
    end

    // Registered outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q     <= CMD_NOP;
            sd_addr   <= '0;
            sd_ba     <= '0;
            sd_cke    <= 1'b1;
            init_done <= 1'b0;
            cfg_error <= 1'b0;
        end else begin
            sd_cke    <= 1'b1;
            sd_ba     <= '0;
            init_done <= (state_d == ST_READY);
            cfg_error <= (state_d == ST_FAULT);
            unique case (state_d)
                ST_PRECHARGE: begin cmd_q <= CMD_PRE; sd_addr <= ALL_BANKS; end
                ST_REFRESH:   begin cmd_q <= CMD_REF; sd_addr <= '0;        end
                ST_MRS:       begin cmd_q <= CMD_MRS; sd_addr <= mode_word; end
                default:      begin cmd_q <= CMD_NOP; sd_addr <= '0;        end
            endcase
        end
    end

    assign sd_cs_n  = cmd_q.cs_n;
    assign sd_ras_n = cmd_q.ras_n;
    assign sd_cas_n = cmd_q.cas_n;
    assign sd_we_n  = cmd_q.we_n;

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cfg_burst_len,
    input logic              cfg_burst_type,
    input logic [2:0]        cfg_cas_lat,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic [BA_W-1:0]   sd_ba,
    input logic              init_done,
    input logic              cfg_error
);

    logic [3:0] cmd;
    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // R1
    cke_high_chk: assert property (@(posedge clk) disable iff (!rst_n) sd_cke);

    // R3
    pre_all_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0010) |-> sd_addr[10]);

    // R6
    mrs_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0000) |-> (sd_addr[ADDR_W-1:7] == '0 && sd_ba == '0));

    // R7
    mrs_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0000) |-> ((sd_addr[6:4] == 3'b010 || sd_addr[6:4] == 3'b011) &&
                             (sd_addr[2] == 1'b0 || (sd_addr[2:0] == 3'b111 && !sd_addr[3]))));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |=> cfg_error);

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R8
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_done && cfg_error));

    // R9
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done || cfg_error) |-> (cmd == 4'b0111 && sd_addr == '0));

endmodule

bind sdram_init_seq sdram_init_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) chk_i (.*);

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;

    localparam int CLK_MHZ = 250;
    localparam int STARTUP_US = 2;
    localparam int TRP = 3;
    localparam int TRFC = 7;
    localparam int TMRD = 2;
    localparam int NREF = 3;
    localparam int S = CLK_MHZ * STARTUP_US;
    localparam int M = S + TRP + NREF * TRFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bl = 3'd0;
    logic        bt = 1'b0;
    logic [2:0]  cas = 3'd2;
    logic        cke, cs_n, ras_n, cas_n, we_n, done, err;
    logic [12:0] addr;
    logic [1:0]  ba;

    int n_tests = 0;
    int n_fail = 0;

    always #2ns clk = ~clk;

    sdram_init_seq #(
        .CLK_MHZ(CLK_MHZ), .STARTUP_US(STARTUP_US), .TRP_CYC(TRP), .TRFC_CYC(TRFC),
        .TMRD_CYC(TMRD), .NUM_REFRESH(NREF), .ADDR_W(13), .BA_W(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cfg_burst_len(bl), .cfg_burst_type(bt),
        .cfg_cas_lat(cas), .sd_cke(cke), .sd_cs_n(cs_n), .sd_ras_n(ras_n),
        .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_addr(addr), .sd_ba(ba),
        .init_done(done), .cfg_error(err)
    );

    function automatic bit exp_legal(logic [2:0] l, logic t, logic [2:0] c);
        bit cok = (c == 3'd2) || (c == 3'd3);
        bit lok = (l <= 3'd3) || (l == 3'd7 && t == 1'b0);
        return cok && lok;
    endfunction

    function automatic logic [12:0] exp_word(logic [2:0] l, logic t, logic [2:0] c);
        logic [12:0] w = '0;
        w[2:0] = l;
        w[3]   = t;
        w[6:4] = c;
        return w;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, int cyc);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    task automatic run_case(logic [2:0] l, logic t, logic [2:0] c);
        bit legal = exp_legal(l, t, c);
        bl = l; bt = t; cas = c;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R10 and R1 during reset
        check("R10", {cs_n, ras_n, cas_n, we_n}, 4'b0111, 0);
        check("R10", {17'd0, addr, ba, done, err}, 32'd0, 0);
        check("R1", cke, 1'b1, 0);
        rst_n = 1'b1;
        for (int k = 1; k <= M + TMRD + 4; k++) begin
            logic [3:0]  ecmd = 4'b0111;
            logic [12:0] eaddr = '0;
            string tag = (k < S) ? "R2" : "R9";
            @(negedge clk);
            if (k == S) begin
                ecmd = 4'b0010; eaddr = 13'h400; tag = "R3";
            end
            for (int i = 0; i < NREF; i++)
                if (k == S + TRP + i * TRFC) begin ecmd = 4'b0001; tag = "R4"; end
            if (k == M) begin
                if (legal) begin ecmd = 4'b0000; eaddr = exp_word(l, t, c); tag = "R5"; end
                else tag = "R7";
                if (legal) check("R6", {addr[12:7], ba}, 8'd0, k);
            end
            check(tag, {15'd0, cs_n, ras_n, cas_n, we_n, addr}, {15'd0, ecmd, eaddr}, k);
            check("R9", ba, 2'b00, k);
            check("R1", cke, 1'b1, k);
            check("R8", done, legal && (k >= M + TMRD), k);
            check("R7", err, !legal && (k >= M), k);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // directed corners
        run_case(3'b011, 1'b0, 3'b010);   // R5 burst 8 sequential, CL2
        run_case(3'b111, 1'b0, 3'b011);   // R7 full page sequential, legal
        run_case(3'b111, 1'b1, 3'b011);   // R7 full page interleave, reserved
        run_case(3'b010, 1'b1, 3'b001);   // R7 reserved CAS latency
        run_case(3'b100, 1'b0, 3'b010);   // R7 reserved burst length
        run_case(3'b000, 1'b1, 3'b011);   // R5 burst 1, interleave bit carried
        // random configurations
        for (int r = 0; r < 12; r++) begin
            logic [2:0] l = 3'($urandom % 8);
            logic       t = 1'($urandom % 2);
            logic [2:0] c = ($urandom % 3 == 0) ? 3'($urandom % 8) : 3'(2 + $urandom % 2);
            run_case(l, t, c);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule